// File: doc/BRIEF.md
# Recursive Sliding and CIC Sum Engine

This block filters sampled signals from up to four input channels that share one sample stream. Each strobe brings a channel index and a signed sample. For that channel the block updates two sums. The first is a length-K sliding (boxcar) sum. The second is a second-order cascaded integrator-comb sum, which equals a length-K sliding sum taken over the length-K sliding sums. Both sums are updated by recursion. Each update reads only two delayed raw samples from a per-channel circular history, so the work per sample stays the same for any window length.

One arithmetic path serves all channels. Each channel keeps its own history, write pointer and accumulators. The path computes the two sums and compares each against a threshold supplied on a port. It returns both sums, two over-threshold flags and a one-hot valid strobe that names the channel. All of these appear on the clock edge that follows the sample strobe.

Top module: `slide_cic_engine`

## Requirements
- R1: One clock edge after a strobe, out_slide equals the sum of the last K samples of that channel, including the current one. Samples that came before reset count as zero.
- R2: One clock edge after a strobe, out_cic equals the sum of the last K sliding-sum values of that channel. This equals the sum over i = 0..2K-2 of w(i)·x[n-i], with w(i) = min(i+1, 2K-1-i).
- R3: One clock edge after a strobe on channel c, out_valid has exactly bit c set (bit c of the vector belongs to channel c).
- R4: Samples on one channel never change the sums of any other channel.
- R5: over_slide is 1 exactly when the new sliding sum is strictly greater than thr_slide, with signed comparison. A sum equal to the threshold gives 0.
- R6: over_cic is 1 exactly when the new CIC sum is strictly greater than thr_cic, with signed comparison. A sum equal to the threshold gives 0.
- R7: Reset clears all history, accumulators and outputs. After reset, the sums cover only samples that arrived after reset.
- R8: Long runs of full-scale positive or full-scale negative samples give exact results, with no overflow: K·x for the sliding sum and K²·x for the CIC sum.
- R9: In a cycle with no strobe, out_valid is all zeros on the next edge, and out_slide, out_cic and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Sample strobe |
| in_ch | input | clog2(NCH) | Channel of the sample |
| in_x | input | W | Signed sample |
| thr_slide | input | W+clog2(K) | Signed limit for the sliding sum |
| thr_cic | input | W+2·clog2(K) | Signed limit for the CIC sum |
| out_valid | output | NCH | One-hot result strobe, bit per channel |
| out_slide | output | W+clog2(K) | Sliding sum of the channel just updated |
| out_cic | output | W+2·clog2(K) | CIC sum of the channel just updated |
| over_slide | output | 1 | Sliding sum above its limit |
| over_cic | output | 1 | CIC sum above its limit |

## Verification
The properties assume that in_ch is always below NCH whenever in_stb is high. They also assume that the thresholds presented with a strobe are the ones that matter for that result. The bench uses a small configuration with four channels, 8-bit samples and K = 5. It only ever drives valid channel numbers, and it changes all inputs on the falling edge. It places each threshold one below, equal to and one above the expected sum in turn. It checks every result against direct weighted sums that it keeps in its own sample record. The runs cover random data, interleaved channels, full-scale extremes and a reset in the middle of the run.

// File: rtl/slide_cic_engine.sv
module slide_cic_engine #(
  parameter int NCH = 4,
  parameter int W   = 16,
  parameter int K   = 124,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LK = $clog2(K),
  localparam int SW = W + LK,
  localparam int YW = W + 2*LK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_stb,
  input  logic [CW-1:0]        in_ch,
  input  logic signed [W-1:0]  in_x,
  input  logic signed [SW-1:0] thr_slide,
  input  logic signed [YW-1:0] thr_cic,
  output logic [NCH-1:0]       out_valid,
  output logic signed [SW-1:0] out_slide,
  output logic signed [YW-1:0] out_cic,
  output logic                 over_slide,
  output logic                 over_cic
);

  localparam int D  = 2*K;
  localparam int PW = $clog2(D);
  localparam int UW = W + LK + 1;

  logic signed [W-1:0]  hist  [NCH][D];
  logic [PW-1:0]        ptr   [NCH];
  logic signed [SW-1:0] s_acc [NCH];
  logic signed [UW-1:0] u_acc [NCH];
  logic signed [YW-1:0] y_acc [NCH];

  wire [PW-1:0] p_now = ptr[in_ch];
  wire [PW-1:0] p_k   = (p_now >= PW'(K)) ? p_now - PW'(K) : p_now + PW'(K);
  wire [PW-1:0] p_nxt = (p_now == PW'(D-1)) ? '0 : p_now + 1'b1;

  wire signed [W-1:0]  x_k  = hist[in_ch][p_k];
  wire signed [W-1:0]  x_2k = hist[in_ch][p_now];

  wire signed [SW-1:0] s_nxt = s_acc[in_ch] + SW'(in_x) - SW'(x_k);
  wire signed [UW-1:0] u_nxt = u_acc[in_ch] + UW'(in_x) - (UW'(x_k) <<< 1) + UW'(x_2k);
  wire signed [YW-1:0] y_nxt = y_acc[in_ch] + YW'(u_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        for (int i = 0; i < D; i++) hist[c][i] <= '0;
        ptr[c]   <= '0;
        s_acc[c] <= '0;
        u_acc[c] <= '0;
        y_acc[c] <= '0;
      end
      out_valid  <= '0;
      out_slide  <= '0;
      out_cic    <= '0;
      over_slide <= 1'b0;
      over_cic   <= 1'b0;
    end else begin
      out_valid <= '0;
      if (in_stb) begin
        hist[in_ch][p_now] <= in_x;
        ptr[in_ch]   <= p_nxt;
        s_acc[in_ch] <= s_nxt;
        u_acc[in_ch] <= u_nxt;
        y_acc[in_ch] <= y_nxt;
        out_valid    <= NCH'(1) << in_ch;
        out_slide    <= s_nxt;
        out_cic      <= y_nxt;
        over_slide   <= s_nxt > thr_slide;
        over_cic     <= y_nxt > thr_cic;
      end
    end
  end

endmodule

module slide_cic_engine_chk #(
  parameter int NCH = 4,
  parameter int W   = 16,
  parameter int K   = 124,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LK = $clog2(K),
  localparam int SW = W + LK,
  localparam int YW = W + 2*LK
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_stb,
  input logic [CW-1:0]        in_ch,
  input logic signed [W-1:0]  in_x,
  input logic signed [SW-1:0] thr_slide,
  input logic signed [YW-1:0] thr_cic,
  input logic [NCH-1:0]       out_valid,
  input logic signed [SW-1:0] out_slide,
  input logic signed [YW-1:0] out_cic,
  input logic                 over_slide,
  input logic                 over_cic
);

  localparam longint SMAX = longint'(K) * (longint'(1) << (W-1));
  localparam longint YMAX = longint'(K) * SMAX;

  a_r3_valid_names_channel: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> ($countones(out_valid) == 1) && out_valid[$past(in_ch)]);

  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> out_valid == '0);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> $stable(out_slide) && $stable(out_cic) && $stable(over_slide) && $stable(over_cic));

  a_r5_slide_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> over_slide == (out_slide > $past(thr_slide)));

  a_r6_cic_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> over_cic == (out_cic > $past(thr_cic)));

  a_r8_slide_range: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(out_slide) <= SMAX) && (longint'(out_slide) >= -SMAX));

  a_r8_cic_range: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(out_cic) <= YMAX) && (longint'(out_cic) >= -YMAX));

endmodule

bind slide_cic_engine slide_cic_engine_chk #(.NCH(NCH), .W(W), .K(K)) u_chk (.*);

// File: tb/sim_slide_cic_engine.sv
module sim_slide_cic_engine;
  localparam int NCH = 4, W = 8, K = 5;
  localparam int SW = W + $clog2(K), YW = W + 2*$clog2(K);

  logic clk = 0, rst_n = 0, in_stb = 0;
  logic [1:0] in_ch = '0;
  logic signed [W-1:0] in_x = '0;
  logic signed [SW-1:0] thr_slide = '0;
  logic signed [YW-1:0] thr_cic = '0;
  logic [NCH-1:0] out_valid;
  logic signed [SW-1:0] out_slide;
  logic signed [YW-1:0] out_cic;
  logic over_slide, over_cic;

  int checks = 0, failures = 0;
  int hx [NCH][0:2047];
  int cnt [NCH];

  always #5 clk = ~clk;

  slide_cic_engine #(.NCH(NCH), .W(W), .K(K)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_slide(input int c);
    longint s = 0;
    for (int i = 0; i < K; i++) if (cnt[c]-1-i >= 0) s += hx[c][cnt[c]-1-i];
    return s;
  endfunction

  function automatic longint ref_cic(input int c);
    longint s = 0;
    for (int i = 0; i <= 2*K-2; i++) begin
      int w = (i+1 < 2*K-1-i) ? i+1 : 2*K-1-i;
      if (cnt[c]-1-i >= 0) s += longint'(w) * hx[c][cnt[c]-1-i];
    end
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_stb = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < NCH; c++) cnt[c] = 0;
    chk(out_valid == 0, "R7 valid after reset", out_valid, 0);
    chk(out_slide == 0, "R7 slide after reset", out_slide, 0);
    chk(out_cic == 0, "R7 cic after reset", out_cic, 0);
    chk(!over_slide && !over_cic, "R7 flags after reset", {over_slide, over_cic}, 0);
  endtask

  task automatic send(input int c, input int x, input int tmode, input string tag);
    longint es, ec, ts, tc;
    hx[c][cnt[c]] = x;
    cnt[c]++;
    es = ref_slide(c);
    ec = ref_cic(c);
    ts = es + tmode - 1;
    tc = ec + 1 - tmode;
    @(negedge clk);
    in_stb = 1; in_ch = 2'(c); in_x = W'(x);
    thr_slide = SW'(ts); thr_cic = YW'(tc);
    @(negedge clk);
    in_stb = 0;
    chk(out_valid == NCH'(1 << c), {"R3 ", tag}, out_valid, 1 << c);
    chk(longint'(out_slide) == es, {"R1 ", tag}, out_slide, es);
    chk(longint'(out_cic) == ec, {"R2 ", tag}, out_cic, ec);
    chk(over_slide == (es > ts), {"R5 ", tag}, over_slide, es > ts);
    chk(over_cic == (ec > tc), {"R6 ", tag}, over_cic, ec > tc);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint ls, lc;
    do_reset();
    // R1 R2: single impulse on ch0 walks out the full weight profile
    send(0, 100, 0, "impulse");
    for (int i = 0; i < 2*K; i++) send(0, 0, i % 3, "impulse tail");
    // R1 R2 R5 R6: random interleaved channels
    for (int n = 0; n < 600; n++) send($urandom_range(0, NCH-1), $urandom_range(0, 255) - 128, n % 3, "random");
    // R4: a burst on ch3 only, then ch2 must still reflect only its own record
    for (int n = 0; n < 3*K; n++) send(3, 127, n % 3, "burst ch3");
    send(2, 0, 1, "R4 isolation ch2");
    send(1, 0, 1, "R4 isolation ch1");
    // R8: full scale extremes
    for (int n = 0; n < 3*K; n++) send(0, 127, n % 3, "R8 max");
    chk(out_slide == SW'(K*127), "R8 slide max", out_slide, K*127);
    chk(out_cic == YW'(K*K*127), "R8 cic max", out_cic, K*K*127);
    for (int n = 0; n < 3*K; n++) send(1, -128, n % 3, "R8 min");
    chk(out_slide == -SW'(K*128), "R8 slide min", out_slide, -K*128);
    chk(out_cic == -YW'(K*K*128), "R8 cic min", out_cic, -K*K*128);
    // R9: idle cycles hold outputs
    ls = out_slide; lc = out_cic;
    in_x = 8'sd77; in_ch = 2'd2; thr_slide = '0; thr_cic = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R9 idle valid", out_valid, 0);
    chk(longint'(out_slide) == ls, "R9 idle slide", out_slide, ls);
    chk(longint'(out_cic) == lc, "R9 idle cic", out_cic, lc);
    // R7: reset mid-run, history must be gone
    do_reset();
    send(0, 55, 1, "R7 first after reset");
    send(1, -9, 0, "R7 other channel after reset");
    for (int n = 0; n < 4*K; n++) send(0, $urandom_range(0, 255) - 128, n % 3, "R7 refill");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule